// File: doc/BRIEF.md
# Key Event Queue with Host Register Port

This block buffers keypad and general-purpose-input events until a host collects them. Each event is one byte: bit 7 is 1 for a press and 0 for a release, and bits 6:0 carry the key code. A producer pushes events one per cycle. The host reads three registers. One holds the interrupt flags. One holds the number of pending events. The third presents the oldest event, and each read of it removes that event from the queue.

The queue holds up to ten events. An arriving event sets a keypad flag or an input flag, depending on its source. A push that finds the queue full is discarded and sets a sticky overflow flag. The host clears any flag by writing 1 to its bit. The active-low interrupt output is asserted while any set flag also has its enable input set.

Top module: `key_event_queue`

## Requirements
- R1: The queue stores up to 10 events, and the count register at address 0x03 returns the live number of stored events in bits 3:0, with bits 7:4 reading 0.
- R2: Event bytes are returned unchanged, in the order they were pushed. Bit 7 is 1 for a press and 0 for a release, and bits 6:0 are the key code.
- R3: A read strobe at address 0x04 returns the oldest event in the same cycle. The count then drops by one and the next event becomes the head.
- R4: When the queue is empty, the count reads 0 and address 0x04 reads 0x00, and a read strobe at 0x04 leaves the count at 0.
- R5: A push that arrives while 10 events are stored, with no pop in the same cycle, is discarded. The stored events are kept, and status bit 2 (overflow) is set.
- R6: Every qualifying keypad push sets status bit 0, and every qualifying input push sets status bit 1. This applies whether the event is stored or dropped. The status register is at address 0x02.
- R7: An input-sourced push (`push_gpi`=1) whose event-mode enable (`push_gpi_en`) is 0 is ignored: it neither enters the queue nor sets a flag.
- R8: A write to address 0x02 clears each status bit whose write-data bit is 1 and leaves the other bits unchanged. If a set and a clear of the same bit happen in the same cycle, the set wins.
- R9: When a push and a head read happen in the same cycle, the pop is applied first and then the push, so the count is unchanged.
- R10: `irq_n` is 0 exactly when some status bit i and `int_en[i]` are both 1.
- R11: After reset the count is 0, the head reads 0x00, all status bits are 0 and `irq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_valid | input | 1 | Event push strobe |
| push_gpi | input | 1 | 1 if the event comes from a general-purpose input, 0 if it comes from the keypad |
| push_gpi_en | input | 1 | Event-mode enable of the input that produced the push |
| push_data | input | 8 | Event byte |
| host_addr | input | 8 | Register address |
| host_rd | input | 1 | Read strobe; pops the queue when the address is 0x04 |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for `host_addr`, valid in the same cycle |
| int_en | input | 3 | Interrupt enable for status bits 2:0 |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The hardest cases to reach are the overflow drop and a pop and push landing in the same cycle. The first needs the queue exactly full when an eleventh push arrives. The second needs a full queue, or a partly filled one, with the read strobe and the push strobe in the same clock. The stimulus fills the queue with ten events, pushes one more, and then drains the queue while a scoreboard queue predicts every head byte. It later sets up a two-entry queue and raises both strobes together, checking the count and the order of what remains.

// File: rtl/keq_pkg.sv
package keq_pkg;
    typedef logic [7:0] evt_t;

    localparam logic [7:0] ADDR_STAT  = 8'h02;
    localparam logic [7:0] ADDR_COUNT = 8'h03;
    localparam logic [7:0] ADDR_HEAD  = 8'h04;

    localparam int STAT_W   = 3;
    localparam int BIT_KEY  = 0;
    localparam int BIT_GPI  = 1;
    localparam int BIT_OVF  = 2;
endpackage

// File: rtl/keq_store.sv
module keq_store
    import keq_pkg::*;
#(
    parameter int DEPTH = 10,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  evt_t          push_data,
    input  logic          pop,
    output evt_t          head,
    output logic [CW-1:0] count,
    output logic          dropped
);
    typedef struct packed {
        evt_t [DEPTH-1:0] slot;
        logic [CW-1:0]    cnt;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        dropped = 1'b0;
        if (pop && st_q.cnt != '0) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                st_d.slot[i] = st_q.slot[i+1];
            end
            st_d.slot[DEPTH-1] = '0;
            st_d.cnt           = st_q.cnt - 1'b1;
        end
        if (push) begin
            if (st_d.cnt == CW'(DEPTH)) begin
                dropped = 1'b1;
            end else begin
                st_d.slot[st_d.cnt] = push_data;
                st_d.cnt            = st_d.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head  = st_q.slot[0];
    assign count = st_q.cnt;
endmodule

// File: rtl/keq_irq.sv
module keq_irq
    import keq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] set_bits,
    input  logic [STAT_W-1:0] clr_bits,
    input  logic [STAT_W-1:0] int_en,
    output logic [STAT_W-1:0] stat,
    output logic              irq_n
);
    typedef struct packed {
        logic [STAT_W-1:0] flags;
    } irq_t;

    irq_t ir_d, ir_q;

    always_comb begin
        ir_d       = ir_q;
        ir_d.flags = (ir_q.flags & ~clr_bits) | set_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ir_q <= '0;
        else        ir_q <= ir_d;
    end

    assign stat  = ir_q.flags;
    assign irq_n = ~|(ir_q.flags & int_en);
endmodule

// File: rtl/key_event_queue.sv
module key_event_queue
    import keq_pkg::*;
#(
    parameter int DEPTH = 10,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        push_valid,
    input  logic        push_gpi,
    input  logic        push_gpi_en,
    input  logic [7:0]  push_data,
    input  logic [7:0]  host_addr,
    input  logic        host_rd,
    input  logic        host_wr,
    input  logic [7:0]  host_wdata,
    output logic [7:0]  host_rdata,
    input  logic [2:0]  int_en,
    output logic        irq_n
);
    logic              push_ok;
    logic              rd_head;
    logic              wr_stat;
    logic              dropped;
    evt_t              head;
    logic [CW-1:0]     fifo_cnt;
    logic [STAT_W-1:0] stat_bits;
    logic [STAT_W-1:0] set_bits;
    logic [STAT_W-1:0] clr_bits;

    assign push_ok = push_valid && (!push_gpi || push_gpi_en);
    assign rd_head = host_rd && (host_addr == ADDR_HEAD);
    assign wr_stat = host_wr && (host_addr == ADDR_STAT);

    keq_store #(.DEPTH(DEPTH), .CW(CW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push_ok),
        .push_data (push_data),
        .pop       (rd_head),
        .head      (head),
        .count     (fifo_cnt),
        .dropped   (dropped)
    );

    always_comb begin
        set_bits          = '0;
        set_bits[BIT_KEY] = push_ok && !push_gpi;
        set_bits[BIT_GPI] = push_ok && push_gpi;
        set_bits[BIT_OVF] = dropped;
        clr_bits          = wr_stat ? host_wdata[STAT_W-1:0] : '0;
    end

    keq_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_bits (set_bits),
        .clr_bits (clr_bits),
        .int_en   (int_en),
        .stat     (stat_bits),
        .irq_n    (irq_n)
    );

    always_comb begin
        unique case (host_addr)
            ADDR_STAT:  host_rdata = 8'(stat_bits);
            ADDR_COUNT: host_rdata = 8'(fifo_cnt);
            ADDR_HEAD:  host_rdata = head;
            default:    host_rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/keq_checks.sv
module keq_checks #(
    parameter int DEPTH = 10,
    parameter int CW    = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          push_valid,
    input logic          push_gpi,
    input logic          push_gpi_en,
    input logic [7:0]    host_addr,
    input logic          host_rd,
    input logic          host_wr,
    input logic [7:0]    host_wdata,
    input logic [7:0]    host_rdata,
    input logic [2:0]    int_en,
    input logic          irq_n,
    input logic [CW-1:0] cnt,
    input logic [2:0]    stat
);
    logic qual, pop;
    assign qual = push_valid && (!push_gpi || push_gpi_en);
    assign pop  = host_rd && host_addr == 8'h04 && cnt != '0;

    // R1
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));

    // R5
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CW'(DEPTH) && qual && !pop) |=> (cnt == CW'(DEPTH) && stat[2]));

    // R3
    pop_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !qual) |=> (cnt == $past(cnt) - 1'b1));

    // R9
    swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && qual) |=> (cnt == $past(cnt)));

    // R4
    empty_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && host_addr == 8'h04) |-> (host_rdata == 8'h00));

    // R8
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == 8'h02 && host_wdata[0] && !(qual && !push_gpi)) |=> !stat[0]);

    // R10
    irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_n == !(|(stat & int_en)));
endmodule

bind key_event_queue keq_checks #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_valid  (push_valid),
    .push_gpi    (push_gpi),
    .push_gpi_en (push_gpi_en),
    .host_addr   (host_addr),
    .host_rd     (host_rd),
    .host_wr     (host_wr),
    .host_wdata  (host_wdata),
    .host_rdata  (host_rdata),
    .int_en      (int_en),
    .irq_n       (irq_n),
    .cnt         (fifo_cnt),
    .stat        (stat_bits)
);

// File: tb/key_event_queue_tb.sv
module key_event_queue_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       push_valid = 0, push_gpi = 0, push_gpi_en = 0;
    logic [7:0] push_data = 0, host_addr = 0, host_wdata = 0;
    logic       host_rd = 0, host_wr = 0;
    logic [7:0] host_rdata;
    logic [2:0] int_en = 3'b111;
    logic       irq_n;

    int total = 0, bad = 0, mcount = 0;
    bit done = 0;
    logic [7:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    key_event_queue #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_gpi(push_gpi),
        .push_gpi_en(push_gpi_en), .push_data(push_data), .host_addr(host_addr),
        .host_rd(host_rd), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .int_en(int_en), .irq_n(irq_n)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic peek(logic [7:0] addr, output logic [7:0] val);
        host_addr = addr;
        #1 val = host_rdata;
    endtask

    task automatic check_reg(string req, logic [7:0] addr, logic [7:0] exp);
        logic [7:0] v;
        peek(addr, v);
        check(req, v, exp);
    endtask

    // driver: push one event, predict acceptance into the scoreboard
    task automatic push(bit gpi, bit gen, logic [7:0] b);
        push_valid = 1; push_gpi = gpi; push_gpi_en = gen; push_data = b;
        if ((!gpi || gen) && mcount < DEPTH) begin
            exp_q.push_back(b);
            mcount++;
        end
        @(negedge clk);
        push_valid = 0; push_gpi = 0; push_gpi_en = 0;
    endtask

    // monitor: read head, compare against the scoreboard
    task automatic pop_head(string req, bit with_push, logic [7:0] b);
        logic [7:0] exp, act;
        host_addr = 8'h04; host_rd = 1;
        if (with_push) begin
            push_valid = 1; push_gpi = 0; push_data = b;
        end
        #1 act = host_rdata;
        exp = (exp_q.size() > 0) ? exp_q.pop_front() : 8'h00;
        if (mcount > 0) mcount--;
        if (with_push) begin
            exp_q.push_back(b);
            mcount++;
        end
        check(req, act, exp);
        @(negedge clk);
        host_rd = 0; push_valid = 0;
    endtask

    task automatic wr_stat(logic [7:0] d);
        host_addr = 8'h02; host_wr = 1; host_wdata = d;
        @(negedge clk);
        host_wr = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] seq [10] = '{8'h81, 8'hA0, 8'h01, 8'h20, 8'h97,
                                 8'h17, 8'hAD, 8'hA9, 8'h29, 8'h2D};
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 reset state
        check_reg("R11 count", 8'h03, 8'h00);
        check_reg("R11 head", 8'h04, 8'h00);
        check_reg("R11 stat", 8'h02, 8'h00);
        check("R11 irq_n", {7'b0, irq_n}, 8'h01);

        foreach (seq[i]) push(0, 0, seq[i]);
        check_reg("R1 count full", 8'h03, 8'h0A);
        check_reg("R6 key flag", 8'h02, 8'h01);
        check("R10 irq asserted", {7'b0, irq_n}, 8'h00);

        push(0, 0, 8'h55);
        check_reg("R5 count kept", 8'h03, 8'h0A);
        check_reg("R5 overflow flag", 8'h02, 8'h05);

        for (int i = 0; i < DEPTH; i++) begin
            pop_head("R2/R3 head order", 0, 8'h00);
            check_reg("R3 count dec", 8'h03, 8'(DEPTH - 1 - i));
        end
        pop_head("R4 empty head", 0, 8'h00);
        check_reg("R4 count stays 0", 8'h03, 8'h00);

        wr_stat(8'h00);
        check_reg("R8 write 0 keeps", 8'h02, 8'h05);
        wr_stat(8'h01);
        check_reg("R8 partial clear", 8'h02, 8'h04);
        wr_stat(8'h07);
        check_reg("R8 clear all", 8'h02, 8'h00);
        check("R10 irq released", {7'b0, irq_n}, 8'h01);

        push(1, 0, 8'h92);
        check_reg("R7 disabled input count", 8'h03, 8'h00);
        check_reg("R7 disabled input flag", 8'h02, 8'h00);
        push(1, 1, 8'h93);
        check_reg("R6 input count", 8'h03, 8'h01);
        check_reg("R6 input flag", 8'h02, 8'h02);

        int_en = 3'b001;
        #1 check("R10 masked", {7'b0, irq_n}, 8'h01);
        int_en = 3'b010;
        #1 check("R10 enabled bit1", {7'b0, irq_n}, 8'h00);

        push(0, 0, 8'h44);
        pop_head("R9 swap head", 1, 8'hC5);
        check_reg("R9 count same", 8'h03, 8'h02);
        pop_head("R9 order after swap", 0, 8'h00);
        pop_head("R9 order after swap", 0, 8'h00);
        check_reg("R1 drained", 8'h03, 8'h00);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule